// File: doc/BRIEF.md
# Multi-Rate Dataflow Fire Scheduler

This block paces a dataflow process graph. A host fills a small schedule table, where each entry carries a fire-link mask and a wait count in base ticks, then sets an enable bit. From then on the block walks the table in a cycle. Each base tick, which comes from the sample clock, either advances the schedule or counts down the wait. When an entry is due, a single-cycle fire pulse goes out on every link that its mask selects. Links named in only some entries fire less often than links named in every entry, so different parts of the graph can run at different sample rates from one base rate.

Each processing unit reports completion on its own done line. If a link comes due again while its unit has not yet reported done, the new fire still goes out, and a sticky overrun flag is raised for that link. The flag marks a point where the schedule stopped being predictable.

Top module: `fire_sequencer`

## Requirements
- R1: After reset all fire outputs and all overrun flags are 0 and sequencing is disabled.
- R2: While disabled, base ticks produce no fire pulses.
- R3: Table entry a is written by `tbl_we` with `tbl_addr`=a. Bit i of `tbl_mask` selects fire-link i, and `tbl_wait` is the wait count. When an entry is due on a base tick sampled at clock edge k, `fire` equals its mask in the cycle after edge k and returns to 0 in the next cycle unless a further tick makes an entry due.
- R4: An entry with wait count w holds for w+1 base ticks. The first tick fires it, and the next w ticks fire nothing.
- R5: The entry after index `len_val` (last valid index, loaded by `len_we`) is entry 0. With a last index of 0, entry 0 repeats on every due tick.
- R6: If a link is due while its unit has neither reported done since the link's previous fire nor reports done in the same cycle, `overrun` bit i is set and the fire pulse is still issued. A done pulse in the same cycle as the due tick counts as done.
- R7: Overrun flags stay set until reset or a write of the enable bit (`en_we`).
- R8: Every write of the enable bit (`en_we` with `en_val`) restarts the schedule at entry 0 with no wait pending and clears all outstanding completions. Writing 0 stops sequencing, and writing 1 starts it, so the first following tick fires entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | AW | Entry index to write |
| tbl_mask | input | NLINK | Fire-link mask of the entry |
| tbl_wait | input | WAITW | Base ticks to wait after the entry fires |
| len_we | input | 1 | Write strobe for the last valid index |
| len_val | input | AW | Last valid entry index |
| en_we | input | 1 | Enable write strobe, restarts the schedule |
| en_val | input | 1 | Enable value |
| base_tick | input | 1 | Base-rate tick, one cycle wide |
| unit_done | input | NLINK | Completion pulse from each unit |
| fire | output | NLINK | Fire pulses, one per link |
| overrun | output | NLINK | Sticky overrun flag per link |

## Verification
The bench goes after the wrap at the last valid index. A pointer that wraps one entry late or early produces a fire sequence that drifts from the expected list after the first lap. It checks the wait countdown, where an off-by-one lets a link fire on a tick that should be silent. It also checks a done pulse that lands in the same cycle as a fresh fire: a design that ignores it would raise a false overrun. A restart after disable must begin again at entry 0 and clear stale overruns, and a table rewrite must take effect on the next lap.

// File: rtl/fire_sequencer.sv
module fire_sequencer #(
  parameter int NLINK = 4,
  parameter int DEPTH = 64,
  parameter int WAITW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [AW-1:0]    tbl_addr,
  input  logic [NLINK-1:0] tbl_mask,
  input  logic [WAITW-1:0] tbl_wait,
  input  logic             len_we,
  input  logic [AW-1:0]    len_val,
  input  logic             en_we,
  input  logic             en_val,
  input  logic             base_tick,
  input  logic [NLINK-1:0] unit_done,
  output logic [NLINK-1:0] fire,
  output logic [NLINK-1:0] overrun
);

  logic [NLINK-1:0] mask_mem [DEPTH];
  logic [WAITW-1:0] wait_mem [DEPTH];

  logic             en_q;
  logic [AW-1:0]    ptr_q, last_q;
  logic [WAITW-1:0] cnt_q;
  logic [NLINK-1:0] busy_q;

  logic             step;
  logic             due;
  logic [NLINK-1:0] fire_now, busy_live;
  logic [AW-1:0]    ptr_nxt;

  assign step      = en_q && base_tick;
  assign due       = step && (cnt_q == '0);
  assign fire_now  = due ? mask_mem[ptr_q] : '0;
  assign busy_live = busy_q & ~unit_done;
  assign ptr_nxt   = (ptr_q == last_q) ? '0 : ptr_q + AW'(1);

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      mask_mem[tbl_addr] <= tbl_mask;
      wait_mem[tbl_addr] <= tbl_wait;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
      busy_q  <= '0;
      fire    <= '0;
      overrun <= '0;
    end else begin
      if (len_we) last_q <= len_val;
      if (en_we) begin
        en_q    <= en_val;
        ptr_q   <= '0;
        cnt_q   <= '0;
        busy_q  <= '0;
        fire    <= '0;
        overrun <= '0;
      end else begin
        fire    <= fire_now;
        busy_q  <= busy_live | fire_now;
        overrun <= overrun | (fire_now & busy_live);
        if (step) begin
          if (cnt_q == '0) begin
            cnt_q <= wait_mem[ptr_q];
            ptr_q <= ptr_nxt;
          end else begin
            cnt_q <= cnt_q - WAITW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/fire_sequencer_chk.sv
module fire_sequencer_chk #(
  parameter int NLINK = 4,
  parameter int WAITW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_we,
  input logic             base_tick,
  input logic             en_q,
  input logic [WAITW-1:0] cnt_q,
  input logic [NLINK-1:0] fire,
  input logic [NLINK-1:0] overrun
);

  // R2
  fire_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (fire == '0));

  // R3
  fire_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |=> (fire == '0));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && cnt_q != '0) |=> (fire == '0));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> ((overrun & $past(overrun)) == $past(overrun)));

  // R6
  overrun_with_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((overrun & ~$past(overrun) & ~fire) == '0));

endmodule

bind fire_sequencer fire_sequencer_chk #(.NLINK(NLINK), .WAITW(WAITW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_we(en_we), .base_tick(base_tick),
  .en_q(en_q), .cnt_q(cnt_q), .fire(fire), .overrun(overrun)
);

// File: tb/fire_sequencer_test.sv
`timescale 1ns/1ps
module fire_sequencer_test;
  localparam int NL = 4;
  localparam int AW = 6;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0, len_we = 1'b0, en_we = 1'b0, en_val = 1'b0, base_tick = 1'b0;
  logic [AW-1:0] tbl_addr = '0, len_val = '0;
  logic [NL-1:0] tbl_mask = '0, unit_done = '0;
  logic [WW-1:0] tbl_wait = '0;
  logic [NL-1:0] fire, overrun;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fire_sequencer #(.NLINK(NL), .DEPTH(64), .WAITW(WW)) uut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_mask(tbl_mask), .tbl_wait(tbl_wait), .len_we(len_we), .len_val(len_val),
    .en_we(en_we), .en_val(en_val), .base_tick(base_tick), .unit_done(unit_done),
    .fire(fire), .overrun(overrun)
  );

  localparam logic [NL-1:0] VMASK [4] = '{4'b0011, 4'b0001, 4'b0101, 4'b1001};
  localparam logic [WW-1:0] VWAIT [4] = '{8'd0, 8'd1, 8'd0, 8'd2};
  localparam logic [NL-1:0] EXPF [12] = '{4'b0011, 4'b0001, 4'b0000, 4'b0101,
                                          4'b1001, 4'b0000, 4'b0000, 4'b0011,
                                          4'b0001, 4'b0000, 4'b0101, 4'b1001};

  task automatic check(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic [NL-1:0] dn);
    base_tick = tk; unit_done = dn;
    @(posedge clk); @(negedge clk);
    base_tick = 1'b0; unit_done = '0;
  endtask

  task automatic wr_tbl(input int a, input logic [NL-1:0] m, input logic [WW-1:0] w);
    tbl_we = 1'b1; tbl_addr = AW'(a); tbl_mask = m; tbl_wait = w;
    @(posedge clk); @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic wr_len(input int l);
    len_we = 1'b1; len_val = AW'(l);
    @(posedge clk); @(negedge clk);
    len_we = 1'b0;
  endtask

  task automatic wr_en(input logic v);
    en_we = 1'b1; en_val = v;
    @(posedge clk); @(negedge clk);
    en_we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fire after reset", fire, '0);
    check("R1 overrun after reset", overrun, '0);

    for (int i = 0; i < 4; i++) wr_tbl(i, VMASK[i], VWAIT[i]);
    wr_len(3);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, '1);
      check("R2 no fire while disabled", fire, '0);
    end

    wr_en(1'b1);
    for (int i = 0; i < 12; i++) begin
      step(1'b1, '1);
      check("R3 R4 R5 schedule vector", fire, EXPF[i]);
    end
    check("R6 no overrun with timely done", overrun, '0);
    step(1'b0, '0);
    check("R3 fire is a single-cycle pulse", fire, '0);

    wr_en(1'b0);
    step(1'b1, '1);
    check("R8 no fire after disable", fire, '0);
    wr_en(1'b1);
    step(1'b1, '1);
    check("R8 restart fires entry 0", fire, 4'b0011);

    step(1'b1, '0);
    check("R6 fire issued despite overrun", fire, 4'b0001);
    check("R6 overrun flag for link 0", overrun, 4'b0001);
    step(1'b1, '1);
    check("R7 overrun stays set", overrun, 4'b0001);
    wr_en(1'b1);
    check("R7 enable write clears overrun", overrun, '0);

    wr_len(0);
    wr_en(1'b1);
    step(1'b1, '1);
    check("R5 last index 0 first tick", fire, 4'b0011);
    step(1'b1, '1);
    check("R5 last index 0 repeats entry 0", fire, 4'b0011);

    wr_tbl(0, 4'b1000, 8'd0);
    wr_en(1'b1);
    step(1'b1, '1);
    check("R3 rewritten entry takes effect", fire, 4'b1000);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule